// File: doc/BRIEF.md
# Interrupt Redirection Controller Core

This block routes up to 24 device interrupt pins to a downstream local interrupt controller. Each pin owns a 64-bit routing entry that sets its vector, delivery mode, destination, destination mode, polarity, trigger mode and mask. Software reaches the entries indirectly. It first writes a register number into a select register, then reads or writes a 32-bit data window, so each routing entry appears as two 32-bit halves.

Every cycle the block samples the pin levels and applies polarity and trigger mode to keep one pending flag per pin. A dispatcher picks the lowest-numbered pin that is pending and eligible, and presents one delivery message on a valid/ready handshake. For pins routed in the external-legacy delivery mode, the vector is first fetched from a legacy controller over a request/acknowledge handshake. Level-triggered pins keep a remote-IRR flag set after delivery. An end-of-interrupt input that carries a vector clears that flag in every matching entry. A still-active unmasked pin is then delivered again.

Top module: `irq_router`

## Requirements
- R1: Only bus offsets 0x00 (select register, 8 bits, read back zero-extended) and 0x10 (data window) are decoded. Reads at any other offset return 0, and writes there change nothing.
- R2: Register 0 is the ID register. Its 4-bit ID is written from and read back in bits 27:24, and all other bits read 0.
- R3: Register 1 is read-only. It reads 0x11 in bits 7:0 and NUM_PINS-1 in bits 23:16, which gives 0x00170011 for 24 pins. Writes to it are ignored.
- R4: Register 0x10+2n selects the low half of entry n and 0x10+2n+1 selects the high half. A window write replaces only the addressed half. Low-half layout: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-IRR 14 (read-only), trigger 15 (1 = level), mask 16. High-half layout: destination 31:24. All other bits read 0. A select value past the last entry, or any unused register number, reads 0 and ignores writes.
- R5: After reset every entry reads with only the mask bit set (low half 0x00010000, high half 0). The ID is 0, the select register is 0, no message is valid and no legacy request is raised.
- R6: When an entry's polarity bit is 1, the pin is active low. Otherwise it is active high.
- R7: For an edge-triggered pin, an inactive-to-active transition while the entry is unmasked makes the pin pending. A transition while the pin is masked is lost. Delivery clears the pending state, and a pin held active is not delivered again.
- R8: A level-triggered pin is pending while it is active. Its delivery sets remote-IRR, and the pin is not delivered again while remote-IRR is set.
- R9: Eligible pins are served in ascending index order, one message per accepted handshake. A message's fields stay stable while it is valid and not accepted, and valid drops in the cycle after acceptance.
- R10: A message carries the entry's destination, destination mode, delivery mode and vector. In delivery mode 3'b111 the vector is instead taken from the legacy controller: the request is held until it is acknowledged, and it never overlaps a valid message.
- R11: An end-of-interrupt clears remote-IRR in every entry whose vector equals the supplied vector. It leaves other entries alone. A still-active, unmasked level pin whose flag was cleared is delivered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Bus offset (low address bits) |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset |
| pin_lvl | input | NUM_PINS | Interrupt pin levels |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |
| msg_valid | output | 1 | Delivery message valid |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_dest | output | 8 | Destination |
| msg_dest_mode | output | 1 | Destination mode |
| msg_dlv_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector |
| leg_req | output | 1 | Vector request to legacy controller |
| leg_ack | input | 1 | Legacy controller supplies vector |
| leg_vector | input | 8 | Vector from legacy controller |

## Verification
A wrong pending or remote-IRR flag does not show up on any register read except remote-IRR itself. It shows as a missing, duplicated or reordered message within a few cycles of the pin change or of the end-of-interrupt. The bench therefore watches for messages that should not come, over a quiet window after each acknowledged delivery, as well as for those that should. Table corruption surfaces at once on window reads, which the bench compares against a shadow copy after random half-entry writes.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;
    localparam int DM_W   = 3;
    localparam int ID_W   = 4;

    localparam logic [7:0] OFS_SELECT = 8'h00;
    localparam logic [7:0] OFS_WINDOW = 8'h10;
    localparam logic [7:0] REG_IDENT  = 8'h00;
    localparam logic [7:0] REG_VERS   = 8'h01;
    localparam logic [7:0] TBL_BASE   = 8'h10;
    localparam logic [7:0] VERS_CONST = 8'h11;
    localparam logic [DM_W-1:0] DM_LEGACY = 3'b111;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              level;
        logic              rirr;
        logic              pol;
        logic              dest_mode;
        logic [DM_W-1:0]   dmode;
        logic [VEC_W-1:0]  vector;
    } route_t;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              dest_mode;
        logic [DM_W-1:0]   dmode;
        logic [VEC_W-1:0]  vector;
    } msg_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEGACY = 2'd1,
        ST_SEND   = 2'd2
    } disp_state_e;

    function automatic logic [31:0] low_word(input route_t e);
        return {15'b0, e.mask, e.level, e.rirr, e.pol, 1'b0,
                e.dest_mode, e.dmode, e.vector};
    endfunction

    function automatic logic [31:0] high_word(input route_t e);
        return {e.dest, 24'b0};
    endfunction

    function automatic msg_t to_msg(input route_t e);
        return '{dest: e.dest, dest_mode: e.dest_mode, dmode: e.dmode, vector: e.vector};
    endfunction

endpackage

// File: rtl/irq_regtable.sv
module irq_regtable
    import irq_router_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           bus_addr,
    input  logic                 bus_wr_en,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_PINS-1:0]  rirr_set,
    input  logic                 eoi_valid,
    input  logic [VEC_W-1:0]     eoi_vector,
    output route_t               tbl [NUM_PINS]
);

    logic [7:0]      sel_q;
    logic [ID_W-1:0] id_q;
    logic [7:0]      rel;
    logic            tbl_hit;
    logic            win_wr;
    logic [31:0]     win_rd;

    assign rel     = sel_q - TBL_BASE;
    assign tbl_hit = (sel_q >= TBL_BASE) && (int'(rel[7:1]) < NUM_PINS);
    assign win_wr  = bus_wr_en && (bus_addr == OFS_WINDOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            id_q  <= '0;
        end else begin
            if (bus_wr_en && bus_addr == OFS_SELECT)
                sel_q <= bus_wdata[7:0];
            if (win_wr && sel_q == REG_IDENT)
                id_q <= bus_wdata[27:24];
        end
    end

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_entry
        logic hit;
        assign hit = win_wr && tbl_hit && (rel[7:1] == 7'(gi));

        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[gi]      <= '0;
                tbl[gi].mask <= 1'b1;
            end else begin
                if (hit && !sel_q[0]) begin
                    tbl[gi].vector    <= bus_wdata[7:0];
                    tbl[gi].dmode     <= bus_wdata[10:8];
                    tbl[gi].dest_mode <= bus_wdata[11];
                    tbl[gi].pol       <= bus_wdata[13];
                    tbl[gi].level     <= bus_wdata[15];
                    tbl[gi].mask      <= bus_wdata[16];
                end
                if (hit && sel_q[0])
                    tbl[gi].dest <= bus_wdata[31:24];
                if (rirr_set[gi])
                    tbl[gi].rirr <= 1'b1;
                else if (eoi_valid && tbl[gi].vector == eoi_vector)
                    tbl[gi].rirr <= 1'b0;
            end
        end
    end

    always_comb begin
        win_rd = '0;
        if (sel_q == REG_IDENT)
            win_rd = {4'b0, id_q, 24'b0};
        else if (sel_q == REG_VERS)
            win_rd = {8'b0, 8'(NUM_PINS - 1), 8'b0, VERS_CONST};
        else if (tbl_hit) begin
            for (int i = 0; i < NUM_PINS; i++) begin
                if (rel[7:1] == 7'(i))
                    win_rd = sel_q[0] ? high_word(tbl[i]) : low_word(tbl[i]);
            end
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_SELECT: bus_rdata = {24'b0, sel_q};
            OFS_WINDOW: bus_rdata = win_rd;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_pin_sense.sv
module irq_pin_sense #(
    parameter int NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [NUM_PINS-1:0] pol_vec,
    input  logic [NUM_PINS-1:0] level_vec,
    input  logic [NUM_PINS-1:0] mask_vec,
    input  logic [NUM_PINS-1:0] pend_clr,
    output logic [NUM_PINS-1:0] pending
);

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
        logic active;
        logic active_q;
        assign active = pin_lvl[gi] ^ pol_vec[gi];

        always_ff @(posedge clk) begin
            if (rst) begin
                active_q    <= 1'b0;
                pending[gi] <= 1'b0;
            end else begin
                active_q <= active;
                if (level_vec[gi])
                    pending[gi] <= active;
                else if (active && !active_q && !mask_vec[gi])
                    pending[gi] <= 1'b1;
                else if (pend_clr[gi])
                    pending[gi] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irq_router_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  msg_t                fields [NUM_PINS],
    input  logic [NUM_PINS-1:0] pending,
    input  logic [NUM_PINS-1:0] mask_vec,
    input  logic [NUM_PINS-1:0] level_vec,
    input  logic [NUM_PINS-1:0] rirr_vec,
    output logic                msg_valid,
    input  logic                msg_ready,
    output msg_t                msg_out,
    output logic                leg_req,
    input  logic                leg_ack,
    input  logic [VEC_W-1:0]    leg_vector,
    output logic [NUM_PINS-1:0] rirr_set,
    output logic [NUM_PINS-1:0] pend_clr
);

    disp_state_e          state_q;
    logic [IDX_W-1:0]     cur_idx;
    logic                 cur_level;
    msg_t                 cur_msg;
    logic [NUM_PINS-1:0]  elig;
    logic                 any;
    logic [IDX_W-1:0]     pick;
    msg_t                 pick_msg;
    logic                 pick_level;
    logic                 fire;
    logic [NUM_PINS-1:0]  cur_onehot;

    assign elig = pending & ~mask_vec & ~(level_vec & rirr_vec);

    always_comb begin
        any        = 1'b0;
        pick       = '0;
        pick_msg   = '0;
        pick_level = 1'b0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any        = 1'b1;
                pick       = IDX_W'(i);
                pick_msg   = fields[i];
                pick_level = level_vec[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cur_idx   <= '0;
            cur_level <= 1'b0;
            cur_msg   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (any) begin
                    cur_idx   <= pick;
                    cur_level <= pick_level;
                    cur_msg   <= pick_msg;
                    state_q   <= (pick_msg.dmode == DM_LEGACY) ? ST_LEGACY : ST_SEND;
                end
                ST_LEGACY: if (leg_ack) begin
                    cur_msg.vector <= leg_vector;
                    state_q        <= ST_SEND;
                end
                ST_SEND: if (msg_ready)
                    state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign msg_valid  = (state_q == ST_SEND);
    assign leg_req    = (state_q == ST_LEGACY);
    assign msg_out    = cur_msg;
    assign fire       = msg_valid && msg_ready;
    assign cur_onehot = NUM_PINS'(1) << cur_idx;
    assign rirr_set   = (fire && cur_level)  ? cur_onehot : '0;
    assign pend_clr   = (fire && !cur_level) ? cur_onehot : '0;

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          bus_addr,
    input  logic                bus_wr_en,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_dest,
    output logic                msg_dest_mode,
    output logic [2:0]          msg_dlv_mode,
    output logic [7:0]          msg_vector,
    output logic                leg_req,
    input  logic                leg_ack,
    input  logic [7:0]          leg_vector
);

    route_t              tbl [NUM_PINS];
    msg_t                fields [NUM_PINS];
    msg_t                msg_out;
    logic [NUM_PINS-1:0] pol_vec, level_vec, mask_vec, rirr_vec;
    logic [NUM_PINS-1:0] pending, rirr_set, pend_clr;

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_split
        assign pol_vec[gi]   = tbl[gi].pol;
        assign level_vec[gi] = tbl[gi].level;
        assign mask_vec[gi]  = tbl[gi].mask;
        assign rirr_vec[gi]  = tbl[gi].rirr;
        assign fields[gi]    = to_msg(tbl[gi]);
    end

    irq_regtable #(.NUM_PINS(NUM_PINS)) u_table (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr_en  (bus_wr_en),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .rirr_set   (rirr_set),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .tbl        (tbl)
    );

    irq_pin_sense #(.NUM_PINS(NUM_PINS)) u_sense (
        .clk       (clk),
        .rst       (rst),
        .pin_lvl   (pin_lvl),
        .pol_vec   (pol_vec),
        .level_vec (level_vec),
        .mask_vec  (mask_vec),
        .pend_clr  (pend_clr),
        .pending   (pending)
    );

    irq_dispatch #(.NUM_PINS(NUM_PINS)) u_disp (
        .clk        (clk),
        .rst        (rst),
        .fields     (fields),
        .pending    (pending),
        .mask_vec   (mask_vec),
        .level_vec  (level_vec),
        .rirr_vec   (rirr_vec),
        .msg_valid  (msg_valid),
        .msg_ready  (msg_ready),
        .msg_out    (msg_out),
        .leg_req    (leg_req),
        .leg_ack    (leg_ack),
        .leg_vector (leg_vector),
        .rirr_set   (rirr_set),
        .pend_clr   (pend_clr)
    );

    assign msg_dest      = msg_out.dest;
    assign msg_dest_mode = msg_out.dest_mode;
    assign msg_dlv_mode  = msg_out.dmode;
    assign msg_vector    = msg_out.vector;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_rdata,
    input logic        msg_valid,
    input logic        msg_ready,
    input logic [7:0]  msg_vector,
    input logic [7:0]  msg_dest,
    input logic        leg_req,
    input logic        leg_ack
);

    assert_dead_offset_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != 8'h00 && bus_addr != 8'h10) |-> bus_rdata == 32'h0);

    assert_msg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest)));

    assert_one_per_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready) |=> !msg_valid);

    assert_leg_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (leg_req && !leg_ack) |=> leg_req);

    assert_leg_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(leg_req && msg_valid));

endmodule

bind irq_router irq_router_chk chk_i (.*);

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;

    localparam int NP = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pin_lvl = '0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_dest;
    logic        msg_dest_mode;
    logic [2:0]  msg_dlv_mode;
    logic [7:0]  msg_vector;
    logic        leg_req;
    logic        leg_ack = 1'b0;
    logic [7:0]  leg_vector = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    logic [31:0] lo_sh [NP];
    logic [31:0] hi_sh [NP];
    logic [3:0]  id_sh;
    logic [7:0]  sel_sh;

    always #10 clk = ~clk;

    irq_router #(.NUM_PINS(NP)) dut_i (.*);

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr_en = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic reg_rd(input logic [7:0] r, output logic [31:0] d);
        bus_wr(8'h00, {24'b0, r});
        bus_rd(8'h10, d);
    endtask

    task automatic reg_wr(input logic [7:0] r, input logic [31:0] d);
        bus_wr(8'h00, {24'b0, r});
        bus_wr(8'h10, d);
    endtask

    function automatic logic [31:0] lo_fmt(input logic [7:0] vec, input logic [2:0] dm,
                                           input logic dmode_b, input logic pol,
                                           input logic lvl, input logic msk);
        return {15'b0, msk, lvl, 1'b0, pol, 1'b0, dmode_b, dm, vec};
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] s);
        if (s == 8'h00) return {4'b0, id_sh, 24'b0};
        if (s == 8'h01) return 32'h00170011;
        if (s >= 8'h10 && s < 8'h10 + 2*NP)
            return s[0] ? hi_sh[(s - 8'h10) >> 1] : lo_sh[(s - 8'h10) >> 1];
        return 32'h0;
    endfunction

    task automatic wait_msg(input int lim, output logic got);
        got = 1'b0;
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            if (msg_valid) begin got = 1'b1; break; end
        end
    endtask

    task automatic accept();
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic quiet(input string req, input int n);
        logic seen;
        seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (msg_valid || leg_req) seen = 1'b1;
        end
        check(req, {31'b0, seen}, 32'h0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NP; i++) begin lo_sh[i] = 32'h00010000; hi_sh[i] = 32'h0; end
        id_sh = '0; sel_sh = '0;
    endtask

    initial begin
        logic [31:0] rd;
        logic got;
        void'($urandom(32'd20240611));
        do_reset();

        // R5 reset state
        @(negedge clk);
        check("R5 msg_valid", {31'b0, msg_valid}, 0);
        check("R5 leg_req", {31'b0, leg_req}, 0);
        bus_rd(8'h00, rd); check("R5 select", rd, 0);
        bus_rd(8'h10, rd); check("R5 id", rd, 0);
        reg_rd(8'h10 + 8'd46, rd); check("R5 entry23 low", rd, 32'h00010000);
        reg_rd(8'h10 + 8'd1, rd);  check("R5 entry0 high", rd, 32'h0);

        // R3 version
        reg_wr(8'h01, 32'hFFFFFFFF);
        bus_rd(8'h10, rd); check("R3 version", rd, 32'h00170011);

        // R2 id
        reg_wr(8'h00, 32'hFFFFFFFF); id_sh = 4'hF;
        bus_rd(8'h10, rd); check("R2 id", rd, 32'h0F000000);

        // R1 select readback and dead offsets
        bus_wr(8'h00, 32'hABCD_EF5A); bus_rd(8'h00, rd); check("R1 select", rd, 32'h5A);
        bus_wr(8'h20, 32'hFFFFFFFF); bus_rd(8'h20, rd); check("R1 dead read", rd, 0);
        bus_rd(8'h00, rd); check("R1 dead write no effect", rd, 32'h5A);

        // R4 random half writes vs shadow (mask forced so no delivery)
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [31:0] d;
            logic [7:0] s;
            op = $urandom_range(0, 9);
            d  = $urandom();
            if (op < 3) begin
                s = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 8'h3F));
                bus_wr(8'h00, {24'b0, s}); sel_sh = s;
            end else if (op < 6) begin
                if (sel_sh >= 8'h10 && sel_sh < 8'h10 + 2*NP && !sel_sh[0]) d = d | 32'h00010000;
                bus_wr(8'h10, d);
                if (sel_sh == 8'h00) id_sh = d[27:24];
                else if (sel_sh >= 8'h10 && sel_sh < 8'h10 + 2*NP) begin
                    if (sel_sh[0]) hi_sh[(sel_sh - 8'h10) >> 1] = d & 32'hFF000000;
                    else           lo_sh[(sel_sh - 8'h10) >> 1] = d & 32'h0001AFFF;
                end
            end else if (op < 9) begin
                bus_rd(8'h10, rd); check("R4 window readback", rd, exp_read(sel_sh));
            end else begin
                bus_wr(8'($urandom_range(8'h11, 8'hFF)), d);
                bus_rd(8'h10, rd); check("R1 R4 stray offset", rd, exp_read(sel_sh));
            end
        end
        check("R5 no message while masked", {31'b0, msg_valid}, 0);

        do_reset();

        // R7 R10 edge delivery with fields
        reg_wr(8'h10 + 8'd7, 32'h05000000);
        reg_wr(8'h10 + 8'd6, lo_fmt(8'h33, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0));
        @(negedge clk); pin_lvl[3] = 1'b1;
        wait_msg(20, got); check("R7 edge delivered", {31'b0, got}, 1);
        check("R10 vector", {24'b0, msg_vector}, 32'h33);
        check("R10 dest", {24'b0, msg_dest}, 32'h05);
        check("R10 dest mode", {31'b0, msg_dest_mode}, 1);
        check("R10 delivery mode", {29'b0, msg_dlv_mode}, 1);
        accept();
        quiet("R7 held pin not redelivered", 12);
        pin_lvl[3] = 1'b0;

        // R7 masked edge lost
        reg_wr(8'h10 + 8'd6, lo_fmt(8'h33, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1));
        @(negedge clk); pin_lvl[3] = 1'b1;
        repeat (4) @(negedge clk); pin_lvl[3] = 1'b0;
        reg_wr(8'h10 + 8'd6, lo_fmt(8'h33, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0));
        quiet("R7 masked edge lost", 12);

        // R6 polarity, active low
        reg_wr(8'h10 + 8'd8, lo_fmt(8'h44, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1));
        reg_wr(8'h10 + 8'd8, lo_fmt(8'h44, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0));
        @(negedge clk); pin_lvl[4] = 1'b1;
        quiet("R6 high is inactive", 8);
        pin_lvl[4] = 1'b0;
        wait_msg(20, got); check("R6 falling edge delivered", {31'b0, got}, 1);
        check("R6 vector", {24'b0, msg_vector}, 32'h44);
        accept();

        // R8 R11 level pin
        reg_wr(8'h10 + 8'd10, lo_fmt(8'h55, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        @(negedge clk); pin_lvl[5] = 1'b1;
        wait_msg(20, got); check("R8 level delivered", {31'b0, got}, 1);
        check("R8 vector", {24'b0, msg_vector}, 32'h55);
        accept();
        quiet("R8 blocked by remote-IRR", 12);
        bus_rd(8'h10, rd); check("R8 remote-IRR set", rd, 32'h0000C055);
        @(negedge clk); eoi_vector = 8'h56; eoi_valid = 1'b1;
        @(negedge clk); eoi_valid = 1'b0;
        quiet("R11 mismatched EOI ignored", 10);
        bus_rd(8'h10, rd); check("R11 flag kept on mismatch", rd, 32'h0000C055);
        eoi_vector = 8'h55; eoi_valid = 1'b1;
        @(negedge clk); eoi_valid = 1'b0;
        wait_msg(20, got); check("R11 redelivered after EOI", {31'b0, got}, 1);
        check("R11 vector", {24'b0, msg_vector}, 32'h55);
        accept();
        pin_lvl[5] = 1'b0;
        @(negedge clk); eoi_valid = 1'b1;
        @(negedge clk); eoi_valid = 1'b0;
        quiet("R8 inactive level not delivered", 10);
        bus_rd(8'h10, rd); check("R11 flag cleared", rd, 32'h00008055);

        // R9 ordering and hold
        reg_wr(8'h10 + 8'd18, lo_fmt(8'h90, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        reg_wr(8'h10 + 8'd14, lo_fmt(8'h70, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        @(negedge clk); pin_lvl[9] = 1'b1; pin_lvl[7] = 1'b1;
        wait_msg(20, got); check("R9 first present", {31'b0, got}, 1);
        check("R9 lower index first", {24'b0, msg_vector}, 32'h70);
        repeat (3) @(negedge clk);
        check("R9 held while not ready", {23'b0, msg_valid, msg_vector}, 32'h170);
        accept();
        check("R9 valid drops after accept", {31'b0, msg_valid}, 0);
        wait_msg(20, got); check("R9 second present", {31'b0, got}, 1);
        check("R9 higher index second", {24'b0, msg_vector}, 32'h90);
        accept();
        quiet("R9 no extra message", 10);
        pin_lvl[9] = 1'b0; pin_lvl[7] = 1'b0;

        // R10 legacy vector
        reg_wr(8'h10 + 8'd20, lo_fmt(8'hAA, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0));
        @(negedge clk); pin_lvl[10] = 1'b1;
        got = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (leg_req) begin got = 1'b1; break; end
        end
        check("R10 legacy request", {31'b0, got}, 1);
        repeat (2) @(negedge clk);
        check("R10 request held", {30'b0, leg_req, msg_valid}, 32'h2);
        leg_vector = 8'hA7; leg_ack = 1'b1;
        @(negedge clk); leg_ack = 1'b0;
        wait_msg(5, got); check("R10 message after ack", {31'b0, got}, 1);
        check("R10 legacy vector used", {24'b0, msg_vector}, 32'hA7);
        check("R10 legacy mode", {29'b0, msg_dlv_mode}, 32'h7);
        accept();
        pin_lvl[10] = 1'b0;

        finish_run();
    end

endmodule